// File: doc/BRIEF.md
# Staged Flash Command Launcher

This block is the register front end of the software-driven command path in a flash memory controller. Software stages up to six 32-bit command words over a simple register bus, writing the higher words first and the lowest word last. The write to the lowest word is the trigger. The block then reads the instruction type from the low seven bits of word 1 and either sends a descriptor to the serial sequencer at once or holds the command until the data-sequence descriptor linked to it arrives. Only the software-command work mode accepts a trigger.

The descriptor goes to a downstream sequencer over a valid/ready handshake. The sequencer finishes a command by pulsing a done line together with a four-bit error-cause vector. The block keeps a busy flag and a command status word, and software reads both through the same register bus. Serial pin timing and the data mover are outside this block.

Top module: `flash_cmd_stager`

## Requirements
- R1: Command words 0 to 5 sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14. Each is written and read back as a full 32-bit value.
- R2: The work mode is held in bits 6:5 of the register at 0x230, and that register reads back with the same layout. A write to offset 0x00 starts a command only when the mode is 1. In modes 0 and 3 the write stores the word and has no effect on the busy flag, the status word or the descriptor handshake.
- R3: A launch whose word-1 type is 0 presents a descriptor on the next cycle. In that descriptor seq_has_data is 0 and seq_cmd holds the words 1 to 4 that were captured at the launch, with word 1 in bits 31:0.
- R4: A launch of type 1 is held pending. Busy goes high and no descriptor is presented. The next launch, if it has type 127, presents a single descriptor: seq_has_data is 1, seq_cmd holds the pending words, seq_dseq holds the data-sequence words 1 to 4, and seq_notify is bit 0 of the word-0 value written by that second launch.
- R5: If a pending type-1 command is followed by a launch of any type other than 127, no descriptor is presented. Busy clears, and the status word reads 0xC001 (completed, failed and invalid sequence).
- R6: From idle, a launch of type 127 or of any type other than 0, 1 and 127 presents no descriptor and leaves the status word at 0xC001.
- R7: Once seq_valid is high, it stays high until seq_ready is sampled high at a clock edge. The descriptor fields stay unchanged for that whole time, even if the command words are rewritten.
- R8: Bit 7 of the register at 0x100 is the busy flag. It is high from an accepted launch until the cycle after seq_done is sampled following the handshake.
- R9: The status word is at 0x44. When seq_done is sampled, bit 15 (completed) is set. Bits 3:0 take the causes from seq_err: bit 3 DQS error, bit 2 CRC error, bit 1 system bus error, bit 0 invalid sequence. Bit 14 (failed) is set if any cause bit is set.
- R10: A launch written while a descriptor is outstanding or being executed is ignored, and the outstanding descriptor is not replaced. It sets the invalid-sequence bit, so the command completes with status 0xC001 even if seq_err is 0.
- R11: An accepted launch clears the completed bit, the failed bit and all cause bits.
- R12: After reset, the busy flag, the status word, the work mode and seq_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| seq_valid | output | 1 | Descriptor valid |
| seq_ready | input | 1 | Sequencer accepts the descriptor |
| seq_cmd | output | 128 | Command-phase words 1 to 4 |
| seq_dseq | output | 128 | Data-sequence words 1 to 4 |
| seq_has_data | output | 1 | The descriptor includes a data phase |
| seq_notify | output | 1 | A done notification was requested |
| seq_done | input | 1 | Sequencer has finished the command |
| seq_err | input | 4 | Error causes reported with seq_done |

## Verification
A wrong controller state becomes visible at the ports within one cycle of the launch that follows it. A missed pending state shows up as seq_valid rising after a type-1 launch. A lost pending state shows up as 0xC001 after the linked type-127 launch, or as busy dropping early. A snapshot that is missing or taken at the wrong time shows up as descriptor bits that change while valid is held or that carry the wrong words. Errors in the status path appear when 0x44 is read on the cycle after seq_done, and again at the next accepted launch if clearing is broken.

// File: rtl/flash_cmd_stager.sv
module flash_cmd_stager #(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter int NW      = 6,
  parameter int CAUSE_W = 4,
  parameter int TYPE_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  seq_valid,
  input  logic                  seq_ready,
  output logic [(NW-2)*DW-1:0]  seq_cmd,
  output logic [(NW-2)*DW-1:0]  seq_dseq,
  output logic                  seq_has_data,
  output logic                  seq_notify,
  input  logic                  seq_done,
  input  logic [CAUSE_W-1:0]    seq_err
);
  localparam int DESC_W = (NW-2)*DW;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h230);
  localparam logic [1:0] MODE_SW = 2'd1;
  localparam logic [TYPE_W-1:0] T_PLAIN = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] T_LEAD  = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] T_DSEQ  = TYPE_W'(127);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_ISSUE, S_WAIT} st_t;

  st_t                state;
  logic [DW-1:0]      word_q [NW];
  logic [1:0]         mode_q;
  logic [DESC_W-1:0]  cmd_q, dseq_q, live;
  logic               data_q, notify_q;
  logic               st_done, st_fail;
  logic [CAUSE_W-1:0] st_cause;

  logic launch, busy, waiting;
  logic [TYPE_W-1:0] itype;
  logic [CAUSE_W-1:0] inv_bit;

  assign launch  = bus_wr && bus_addr == '0 && mode_q == MODE_SW;
  assign itype   = word_q[1][TYPE_W-1:0];
  assign busy    = state != S_IDLE;
  assign waiting = state == S_WAIT;
  assign inv_bit = CAUSE_W'(1);

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) word_q[i] <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(4*i)) word_q[i] <= bus_wdata;
  end

  for (genvar i = 0; i < NW-2; i++) begin : g_live
    assign live[i*DW +: DW] = word_q[i+1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= '0;
    else if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cmd_q    <= '0;
      dseq_q   <= '0;
      data_q   <= 1'b0;
      notify_q <= 1'b0;
      st_done  <= 1'b0;
      st_fail  <= 1'b0;
      st_cause <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          st_done  <= 1'b0;
          st_fail  <= 1'b0;
          st_cause <= '0;
          if (itype == T_PLAIN) begin
            cmd_q    <= live;
            data_q   <= 1'b0;
            notify_q <= 1'b0;
            state    <= S_ISSUE;
          end else if (itype == T_LEAD) begin
            cmd_q <= live;
            state <= S_PEND;
          end else begin
            st_done  <= 1'b1;
            st_fail  <= 1'b1;
            st_cause <= inv_bit;
          end
        end
        S_PEND: if (launch) begin
          if (itype == T_DSEQ) begin
            dseq_q   <= live;
            data_q   <= 1'b1;
            notify_q <= bus_wdata[0];
            state    <= S_ISSUE;
          end else begin
            st_done  <= 1'b1;
            st_fail  <= 1'b1;
            st_cause <= inv_bit;
            state    <= S_IDLE;
          end
        end
        S_ISSUE: begin
          if (launch) st_cause <= st_cause | inv_bit;
          if (seq_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (seq_done) begin
            st_done  <= 1'b1;
            st_fail  <= |(st_cause | seq_err | (launch ? inv_bit : '0));
            st_cause <= st_cause | seq_err | (launch ? inv_bit : '0);
            state    <= S_IDLE;
          end else if (launch) begin
            st_cause <= st_cause | inv_bit;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign seq_valid    = state == S_ISSUE;
  assign seq_cmd      = cmd_q;
  assign seq_dseq     = dseq_q;
  assign seq_has_data = data_q;
  assign seq_notify   = notify_q;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NW; i++)
      if (bus_addr == ADDR_W'(4*i)) bus_rdata = word_q[i];
    if (bus_addr == A_STAT)
      bus_rdata = DW'({st_done, st_fail, 10'b0, st_cause});
    if (bus_addr == A_CTRL)
      bus_rdata = DW'({busy, 7'b0});
    if (bus_addr == A_MODE)
      bus_rdata = DW'({mode_q, 5'b0});
  end
endmodule

// File: rtl/flash_cmd_stager_chk.sv
module flash_cmd_stager_chk #(
  parameter int DESC_W = 128,
  parameter int TYPE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch,
  input logic              busy,
  input logic              waiting,
  input logic              mode_ok,
  input logic              wr_trig,
  input logic [TYPE_W-1:0] itype,
  input logic              st_done,
  input logic              st_fail,
  input logic              seq_valid,
  input logic              seq_ready,
  input logic              seq_done,
  input logic [DESC_W-1:0] seq_cmd,
  input logic [DESC_W-1:0] seq_dseq,
  input logic              seq_has_data
);
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && !seq_ready |=> seq_valid && $stable(seq_cmd) && $stable(seq_dseq) && $stable(seq_has_data));

  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |-> busy);

  p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trig && !mode_ok |=> $stable(busy) && $stable(st_done) && $stable(st_fail) && !$rose(seq_valid));

  p_done_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && seq_done |=> st_done && !busy);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !busy && itype == '0 |=> !st_done && !st_fail && seq_valid);
endmodule

bind flash_cmd_stager flash_cmd_stager_chk #(.DESC_W((NW-2)*DW), .TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .waiting(waiting),
  .mode_ok(mode_q == 2'd1), .wr_trig(bus_wr && bus_addr == '0), .itype(itype),
  .st_done(st_done), .st_fail(st_fail), .seq_valid(seq_valid),
  .seq_ready(seq_ready), .seq_done(seq_done), .seq_cmd(seq_cmd),
  .seq_dseq(seq_dseq), .seq_has_data(seq_has_data)
);

// File: tb/tb_flash_cmd_stager.sv
module tb_flash_cmd_stager;
  localparam int CLK_P = 10;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic seq_valid, seq_ready = 0, seq_has_data, seq_notify, seq_done = 0;
  logic [127:0] seq_cmd, seq_dseq;
  logic [3:0] seq_err = '0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_stager dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_valid(seq_valid),
    .seq_ready(seq_ready), .seq_cmd(seq_cmd), .seq_dseq(seq_dseq),
    .seq_has_data(seq_has_data), .seq_notify(seq_notify),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  localparam logic [131:0] VEC [4] = '{
    {32'h0000_0000, 32'h1111_2222, 32'h0003_0000, 32'h0000_0100, 4'h0},
    {32'hAB00_0000, 32'h3344_5566, 32'h3002_0077, 32'h0000_1301, 4'h4},
    {32'h5A00_0000, 32'hDEAD_BEEF, 32'h4001_00C5, 32'h0000_2200, 4'h9},
    {32'hFF00_0000, 32'h0000_0000, 32'h0000_0006, 32'h0000_7303, 4'hE}
  };

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic stage(logic [31:0] w1, logic [31:0] w2, logic [31:0] w3, logic [31:0] w4);
    wr(12'h14, 32'h0);
    wr(12'h10, w4);
    wr(12'h0C, w3);
    wr(12'h08, w2);
    wr(12'h04, w1);
  endtask

  task automatic handshake();
    @(negedge clk); seq_ready = 1;
    @(negedge clk); seq_ready = 0;
  endtask

  task automatic finish_cmd(logic [3:0] e);
    @(negedge clk); seq_done = 1; seq_err = e;
    @(negedge clk); seq_done = 0; seq_err = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [127:0] first;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(12'h044, r); check("R12 status after reset", r, 0);
    rd(12'h100, r); check("R12 busy after reset", r, 0);
    rd(12'h230, r); check("R12 mode after reset", r, 0);
    check("R12 valid after reset", seq_valid, 0);

    stage(32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003, 32'hD4D4_0004);
    wr(12'h14, 32'hE5E5_0005);
    rd(12'h004, r); check("R1 word1 readback", r, 32'hA1A1_0001);
    rd(12'h010, r); check("R1 word4 readback", r, 32'hD4D4_0004);
    rd(12'h014, r); check("R1 word5 readback", r, 32'hE5E5_0005);

    wr(12'h04, 32'h0);
    wr(12'h00, 32'h0);
    rd(12'h100, r); check("R2 no launch in mode 0", r, 0);
    check("R2 no descriptor in mode 0", seq_valid, 0);
    wr(12'h230, 32'h60);
    rd(12'h230, r); check("R2 mode 3 readback", r, 32'h60);
    wr(12'h00, 32'h0);
    rd(12'h100, r); check("R2 no launch in mode 3", r, 0);
    wr(12'h230, 32'h20);
    rd(12'h230, r); check("R2 mode 1 readback", r, 32'h20);

    for (int i = 0; i < 4; i++) begin
      logic [127:0] exp_cmd;
      logic [3:0] e;
      logic [31:0] exp_st;
      exp_cmd = {VEC[i][35:4], VEC[i][67:36], VEC[i][99:68], VEC[i][131:100]};
      e = VEC[i][3:0];
      exp_st = 32'h8000 | (e != 0 ? 32'h4000 : 0) | {28'h0, e};
      stage(VEC[i][131:100], VEC[i][99:68], VEC[i][67:36], VEC[i][35:4]);
      wr(12'h00, 32'h0);
      check("R3 valid after type-0 launch", seq_valid, 1);
      check("R3 descriptor words", seq_cmd, exp_cmd);
      check("R3 no data phase", seq_has_data, 0);
      rd(12'h100, r); check("R8 busy during command", r, 32'h80);
      rd(12'h044, r); check("R11 status cleared on launch", r, 0);
      handshake();
      check("R7 valid drops after ready", seq_valid, 0);
      rd(12'h100, r); check("R8 busy until done", r, 32'h80);
      finish_cmd(e);
      rd(12'h100, r); check("R8 busy clear after done", r, 0);
      rd(12'h044, r); check("R9 final status", r, exp_st);
    end

    stage(32'h0000_0000, 32'h0101_0101, 32'h0202_0202, 32'h0303_0303);
    wr(12'h00, 32'h0);
    first = seq_cmd;
    repeat (3) @(negedge clk);
    wr(12'h08, 32'hFFFF_FFFF);
    check("R7 valid held without ready", seq_valid, 1);
    check("R7 descriptor stable", seq_cmd, first);
    handshake();
    stage(32'h0000_0000, 32'h9999_9999, 32'h0, 32'h0);
    wr(12'h00, 32'h0);
    check("R10 ignored launch gives no descriptor", seq_valid, 0);
    rd(12'h100, r); check("R10 still busy", r, 32'h80);
    finish_cmd(4'h0);
    rd(12'h044, r); check("R10 invalid-sequence flagged", r, 32'hC001);

    stage(32'h7700_0001, 32'h1234_5678, 32'h1003_009F, 32'h0000_0301);
    wr(12'h00, 32'h0);
    check("R4 no descriptor while pending", seq_valid, 0);
    rd(12'h100, r); check("R4 busy while pending", r, 32'h80);
    rd(12'h044, r); check("R11 status cleared by type-1", r, 0);
    stage(32'h0000_007F, 32'h0200_0000, 32'h0080_0000, 32'h0000_0210);
    wr(12'h00, 32'h1);
    check("R4 linked descriptor valid", seq_valid, 1);
    check("R4 has data", seq_has_data, 1);
    check("R4 notify from word0 bit0", seq_notify, 1);
    check("R4 command words", seq_cmd, {32'h0000_0301, 32'h1003_009F, 32'h1234_5678, 32'h7700_0001});
    check("R4 data-sequence words", seq_dseq, {32'h0000_0210, 32'h0080_0000, 32'h0200_0000, 32'h0000_007F});
    handshake();
    finish_cmd(4'h0);
    rd(12'h044, r); check("R9 linked command completes clean", r, 32'h8000);

    stage(32'h0000_0001, 32'h0, 32'h0, 32'h0);
    wr(12'h00, 32'h0);
    wr(12'h04, 32'h0);
    wr(12'h00, 32'h0);
    check("R5 no descriptor on broken pair", seq_valid, 0);
    rd(12'h100, r); check("R5 busy cleared", r, 0);
    rd(12'h044, r); check("R5 invalid status", r, 32'hC001);

    wr(12'h04, 32'h0000_007F);
    wr(12'h00, 32'h0);
    check("R6 lone data-sequence no descriptor", seq_valid, 0);
    rd(12'h044, r); check("R6 lone data-sequence status", r, 32'hC001);
    wr(12'h04, 32'h0000_0005);
    wr(12'h00, 32'h0);
    rd(12'h044, r); check("R6 unknown type status", r, 32'hC001);
    rd(12'h100, r); check("R6 not busy", r, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule